// File: doc/BRIEF.md
# GPIO Port with Reset-Strap Capture

This block is a general-purpose input/output port on a simple single-cycle register bus. Each of its pins can be read back as an input, driven from an output data register, and switched between driving and listening by an output-enable register. Every incoming pin passes through a multi-flop synchronizer before any logic uses it, because the pins change asynchronously and may have slow edges.

While reset is asserted, the port keeps sampling the synchronized pin levels. It holds the last sample as a set of configuration straps. The first read of the input register after reset returns these straps instead of the live pins. This lets boot software learn how the board was strapped. The one-shot strap read is lost if any other bus access reaches the port first, including a write to the input register itself. After that, the input register always shows the live pins.

The upper half of the lines (from `IRQ_LO` upward) can each raise an interrupt on a synchronized edge of a chosen polarity. Sticky status bits record these edges. A single request output is asserted while any enabled status bit is set.

Top module: `gpio_strap_port`

## Requirements
- R1: While reset is asserted and after it is released with no bus activity, `gpio_out`, `gpio_oe`, `gpio_irq` and `bus_rdata` are all zero, so every line is an input.
- R2: Each pin passes through `SYNC_STAGES` (at least two) flip-flops. A read of the input register (byte offset 0x00) returns the pin levels once they have been steady for `SYNC_STAGES`+1 clocks, provided the strap read is no longer pending.
- R3: The strap value is the last synchronized pin sample taken while reset is asserted. It does not change while reset stays released.
- R4: The first bus access after reset, if it is a read of offset 0x00, returns the strap value rather than the live pins.
- R5: Any bus access cancels the pending strap read. This covers a write to 0x00 and a read or write of any other offset. Every later read of 0x00 returns the live pins, and only a new reset re-arms the strap read.
- R6: Offset 0x04 holds output data and drives `gpio_out`. Offset 0x08 holds the output enable and drives `gpio_oe`, where 1 means drive. Both read back what was written.
- R7: Bit i of the interrupt status register (offset 0x14) belongs to pin i, for i from `IRQ_LO` to `WIDTH`-1. The bit is set by a synchronized edge of pin i whose direction matches polarity bit i at offset 0x10 (1 = rising, 0 = falling). In the enable (0x0C), polarity and status registers, bits below `IRQ_LO` read as zero.
- R8: A status bit is set whether or not its enable bit at 0x0C is set. `gpio_irq` is 1 exactly when some status bit and its enable bit are both 1.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An edge detected in the same cycle as the clear wins, and the bit stays set.
- R10: Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read. Offsets 0x18 and 0x1C read as zero. A write to 0x00 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; straps are sampled while it is low |
| gpio_in | input | WIDTH | Asynchronous pin levels |
| gpio_out | output | WIDTH | Output data towards the pads |
| gpio_oe | output | WIDTH | Per-line drive enable, 1 = drive |
| gpio_irq | output | 1 | Interrupt request |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |

## Verification
The bench builds the block with its defaults: 16 lines, interrupts on lines 15 to 8, two synchronizer stages and a 5-bit address. With 16 lines, any strap pattern and live pattern can differ in every bit. With two stages, a pin change reaches the status bits within three clocks, so a short fixed wait after each change is enough. The 5-bit address covers two unmapped offsets, which exercise the zero read-back. Several resets with different strap patterns are each followed by a different first access, so both the strap read and each way of cancelling it are exercised.

// File: rtl/gpio_strap_pkg.sv
`timescale 1ns/1ps
package gpio_strap_pkg;
  // Register word indexes (byte offset / 4)
  localparam int REG_IN   = 0;
  localparam int REG_OUT  = 1;
  localparam int REG_OE   = 2;
  localparam int REG_IEN  = 3;
  localparam int REG_POL  = 4;
  localparam int REG_STAT = 5;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  // Not reset: the chain must keep running during reset for strap capture.
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= pin_async;

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) chain[k] <= chain[k-1];
  end

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_strap.sv
`timescale 1ns/1ps
module gpio_strap #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic             any_access,
  output logic [WIDTH-1:0] strap,
  output logic             pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap   <= pin_sync;
      pending <= 1'b1;
    end else if (any_access) begin
      pending <= 1'b0;
    end
  end

  // R3: straps frozen once reset is released
  a_r3_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap));

  // R5: pending flag only drops because of a bus access
  a_r5_pending_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(any_access));

  // R5: nothing but reset re-arms the strap read
  a_r5_pending_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pending));

  // R5: an access while pending always cancels it
  a_r5_access_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && any_access) |=> !pending);
endmodule

// File: rtl/gpio_irq.sv
`timescale 1ns/1ps
module gpio_irq #(
  parameter int WIDTH  = 16,
  parameter int IRQ_LO = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIDTH-IRQ_LO-1:0] line_sync,
  input  logic                    ien_we,
  input  logic                    pol_we,
  input  logic                    stat_we,
  input  logic [WIDTH-IRQ_LO-1:0] wdata,
  output logic [WIDTH-IRQ_LO-1:0] ien,
  output logic [WIDTH-IRQ_LO-1:0] pol,
  output logic [WIDTH-IRQ_LO-1:0] status,
  output logic [WIDTH-IRQ_LO-1:0] hit,
  output logic                    irq
);
  localparam int NIRQ = WIDTH - IRQ_LO;

  // Edge that matches polarity: rising where pol=1, falling where pol=0
  function automatic logic [NIRQ-1:0] edge_match(input logic [NIRQ-1:0] cur,
                                                  input logic [NIRQ-1:0] prev,
                                                  input logic [NIRQ-1:0] p);
    return (cur & ~prev & p) | (~cur & prev & ~p);
  endfunction

  logic [NIRQ-1:0] line_prev;
  logic [NIRQ-1:0] clr_mask;

  // Tracks during reset too, so release creates no false edge
  always_ff @(posedge clk) line_prev <= line_sync;

  assign hit      = edge_match(line_sync, line_prev, pol);
  assign clr_mask = stat_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien    <= '0;
      pol    <= '0;
      status <= '0;
    end else begin
      if (ien_we) ien <= wdata;
      if (pol_we) pol <= wdata;
      status <= (status & ~clr_mask) | hit;
    end
  end

  assign irq = |(status & ien);

  // R7/R9: a detected edge always leaves its status bit set
  a_r7_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status & $past(hit)) == $past(hit)));

  // R7: a status bit never appears without a detected edge
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status & ~$past(status) & ~$past(hit)) == '0));

  // R9: write-one-to-clear removes bits that saw no edge
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && ((wdata & ~hit) != '0)) |=> ((status & $past(wdata & ~hit)) == '0));
endmodule

// File: rtl/gpio_strap_port.sv
`timescale 1ns/1ps
module gpio_strap_port
  import gpio_strap_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int IRQ_LO      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  gpio_in,
  output logic [WIDTH-1:0]  gpio_out,
  output logic [WIDTH-1:0]  gpio_oe,
  output logic              gpio_irq,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata
);
  localparam int NIRQ  = WIDTH - IRQ_LO;
  localparam int IDX_W = ADDR_W - 2;

  function automatic logic hits(input logic [IDX_W-1:0] idx, input int reg_id);
    return int'(idx) == reg_id;
  endfunction

  function automatic logic [WIDTH-1:0] place_hi(input logic [NIRQ-1:0] v);
    return {v, {IRQ_LO{1'b0}}};
  endfunction

  logic [IDX_W-1:0] idx;
  logic             rd_evt, wr_evt;
  logic             unused_lsb;
  logic [WIDTH-1:0] pin_s, strap, rd_mux;
  logic             pending;
  logic [NIRQ-1:0]  ien, pol, status, hit;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign rd_evt     = bus_valid & ~bus_write;
  assign wr_evt     = bus_valid & bus_write;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pin_async(gpio_in), .pin_sync(pin_s));

  gpio_strap #(.WIDTH(WIDTH)) u_strap (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_s), .any_access(bus_valid),
    .strap(strap), .pending(pending));

  gpio_irq #(.WIDTH(WIDTH), .IRQ_LO(IRQ_LO)) u_irq (
    .clk(clk), .rst_n(rst_n), .line_sync(pin_s[WIDTH-1:IRQ_LO]),
    .ien_we(wr_evt && hits(idx, REG_IEN)),
    .pol_we(wr_evt && hits(idx, REG_POL)),
    .stat_we(wr_evt && hits(idx, REG_STAT)),
    .wdata(bus_wdata[WIDTH-1:IRQ_LO]),
    .ien(ien), .pol(pol), .status(status), .hit(hit), .irq(gpio_irq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpio_out <= '0;
      gpio_oe  <= '0;
    end else begin
      if (wr_evt && hits(idx, REG_OUT)) gpio_out <= bus_wdata;
      if (wr_evt && hits(idx, REG_OE))  gpio_oe  <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (hits(idx, REG_IN))   rd_mux = pending ? strap : pin_s;
    else if (hits(idx, REG_OUT))  rd_mux = gpio_out;
    else if (hits(idx, REG_OE))   rd_mux = gpio_oe;
    else if (hits(idx, REG_IEN))  rd_mux = place_hi(ien);
    else if (hits(idx, REG_POL))  rd_mux = place_hi(pol);
    else if (hits(idx, REG_STAT)) rd_mux = place_hi(status);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_evt) bus_rdata <= rd_mux;
  end

  // R4: pending input read returns the captured straps
  a_r4_strap_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && hits(idx, REG_IN) && pending) |=> (bus_rdata == $past(strap)));

  // R10: read data holds when no read was issued
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !rd_evt) |=> $stable(bus_rdata));

  // R8: request only with an enabled, set status bit
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_irq |-> ((status & ien) != '0));

  // R1: no lines driven in the first cycle after reset release
  a_r1_reset_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (gpio_oe == '0 && gpio_out == '0));
endmodule

// File: tb/gpio_strap_port_tb.sv
`timescale 1ns/1ps
module gpio_strap_port_tb;
  localparam logic [15:0] UP = 16'hFF00;
  localparam logic [4:0] A_IN = 5'h00, A_OUT = 5'h04, A_OE = 5'h08,
                         A_IEN = 5'h0C, A_POL = 5'h10, A_STAT = 5'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] pins = 16'hA5C3;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] gpio_out, gpio_oe, bus_rdata;
  logic gpio_irq;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_out, m_oe, m_ien, m_pol, m_st, m_pins;

  always #10 clk = ~clk;

  gpio_strap_port u_dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(pins), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .gpio_irq(gpio_irq), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] edges(input logic [15:0] o, input logic [15:0] n,
                                        input logic [15:0] p);
    logic [15:0] r = '0;
    for (int i = 8; i < 16; i++) begin
      if (p[i] && !o[i] && n[i]) r[i] = 1'b1;
      if (!p[i] && o[i] && !n[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic exp_irq();
    return (m_st & m_ien) != 16'h0;
  endfunction

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_pins(input logic [15:0] v);
    m_st   = m_st | edges(m_pins, v, m_pol);
    m_pins = v;
    @(negedge clk);
    pins = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_reset(input logic [15:0] v);
    @(negedge clk);
    pins = v; rst_n = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    m_out = '0; m_oe = '0; m_ien = '0; m_pol = '0; m_st = '0; m_pins = v;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] d, v, w;
    void'($urandom(32'h5EED_0042));

    do_reset(16'hA5C3);
    chk("R1 out", gpio_out, 16'h0);
    chk("R1 oe", gpio_oe, 16'h0);
    chk("R1 irq", {15'h0, gpio_irq}, 16'h0);
    chk("R1 rdata", bus_rdata, 16'h0);

    // R4 strap on first read, then R5 live afterwards
    set_pins(16'h1234);
    bus_rd(A_IN, d); chk("R4 first read strap", d, 16'hA5C3);
    bus_rd(A_IN, d); chk("R5 second read live", d, 16'h1234);

    // R5 cancelled by write to another register
    do_reset(16'h5A0F);
    set_pins(16'h0F0F);
    bus_wr(A_OUT, 16'h00FF); m_out = 16'h00FF;
    bus_rd(A_IN, d); chk("R5 cancel by out write", d, 16'h0F0F);
    chk("R6 out port", gpio_out, 16'h00FF);

    // R5 cancelled by write to input register; R10 that write changes nothing
    do_reset(16'hC003);
    set_pins(16'h3CC3);
    bus_wr(A_IN, 16'hFFFF);
    bus_rd(A_IN, d); chk("R5 cancel by input write", d, 16'h3CC3);
    bus_rd(A_OUT, d); chk("R10 input write ignored out", d, 16'h0000);
    chk("R10 input write ignored oe", gpio_oe, 16'h0000);

    // R5 cancelled by read of another register; R3 new straps
    do_reset(16'h7E81);
    set_pins(16'h8118);
    bus_rd(A_STAT, d); chk("R7 status after falling edges", d, m_st);
    bus_rd(A_IN, d); chk("R5 cancel by status read", d, 16'h8118);

    // R3: fresh reset captures new straps
    do_reset(16'h9669);
    set_pins(16'h0000);
    bus_rd(A_IN, d); chk("R3 new strap captured", d, 16'h9669);

    // R10 unmapped offsets
    bus_rd(5'h18, d); chk("R10 unmapped 0x18", d, 16'h0);
    bus_rd(5'h1C, d); chk("R10 unmapped 0x1C", d, 16'h0);

    // R7 lower bits read zero
    bus_wr(A_IEN, 16'hFFFF); bus_rd(A_IEN, d); chk("R7 ien lower zero", d, 16'hFF00);
    bus_wr(A_IEN, 16'h0000);
    bus_wr(A_POL, 16'hFF00); m_pol = 16'hFF00;
    bus_rd(A_POL, d); chk("R7 pol readback", d, 16'hFF00);
    bus_wr(A_STAT, 16'hFFFF); m_st = '0;

    // R8: status set though not enabled, irq low
    set_pins(16'h0200);
    bus_rd(A_STAT, d); chk("R8 status without enable", d, 16'h0200);
    chk("R8 irq masked", {15'h0, gpio_irq}, 16'h0);
    bus_wr(A_IEN, 16'h0200); m_ien = 16'h0200;
    chk("R8 irq enabled", {15'h0, gpio_irq}, 16'h1);
    // lower lines never raise status
    set_pins(16'h02FF);
    bus_rd(A_STAT, d); chk("R7 lower lines no status", d, 16'h0200);
    // R9 write 0 keeps, write 1 clears
    bus_wr(A_STAT, 16'h0000);
    bus_rd(A_STAT, d); chk("R9 write zero keeps", d, 16'h0200);
    bus_wr(A_STAT, 16'h0200); m_st = '0;
    bus_rd(A_STAT, d); chk("R9 write one clears", d, 16'h0000);
    chk("R9 irq drops", {15'h0, gpio_irq}, 16'h0);

    // Constrained random mix
    for (int it = 0; it < 80; it++) begin
      case ($urandom % 4)
        0: begin
          v = 16'($urandom); w = 16'($urandom);
          bus_wr(A_OUT, v); m_out = v;
          bus_wr(A_OE, w);  m_oe = w;
          bus_rd(A_OUT, d); chk("R6 out readback", d, m_out);
          bus_rd(A_OE, d);  chk("R6 oe readback", d, m_oe);
          chk("R6 out port", gpio_out, m_out);
          chk("R6 oe port", gpio_oe, m_oe);
        end
        1: begin
          set_pins(16'($urandom));
          bus_rd(A_IN, d);   chk("R2 live input", d, m_pins);
          bus_rd(A_STAT, d); chk("R7 status edges", d, m_st);
          chk("R8 irq", {15'h0, gpio_irq}, {15'h0, exp_irq()});
        end
        2: begin
          v = 16'($urandom); w = 16'($urandom);
          bus_wr(A_POL, v); m_pol = v & UP;
          bus_wr(A_IEN, w); m_ien = w & UP;
          chk("R8 irq after enable", {15'h0, gpio_irq}, {15'h0, exp_irq()});
        end
        default: begin
          v = 16'($urandom);
          bus_wr(A_STAT, v); m_st = m_st & ~v;
          bus_rd(A_STAT, d); chk("R9 random clear", d, m_st);
          chk("R8 irq after clear", {15'h0, gpio_irq}, {15'h0, exp_irq()});
        end
      endcase
    end

    finish_run();
  end
endmodule